// File: doc/BRIEF.md
# GPIO Pin Level Resolver

This block works out the sensed level of each pin of a general-purpose I/O port. It looks at each pin's configuration (direction, output type, pull resistor, output data) and at what the outside world does to the pin. From these it produces a held input-data vector and a set of per-pin output level lines. The outside world reaches each pin through a per-pin drive request that carries a level, and a per-pin release request.

For each pin the block keeps two pieces of state: whether something external is connected, and at what level. It accepts an external drive only when that drive cannot fight the pin's own output driver. When the configuration changes, it cuts any external connection that would now conflict. A pin that nothing determines (floating, no pull) keeps its last sensed value. Alternate-function and analog settings are treated as input.

Software or a register file supplies the configuration vectors as levels. It pulses `cfg_update` whenever they change, so the resolver re-evaluates every pin in the following cycle.

Top module: `gpio_pin_resolver`

## Requirements
- R1: A pin in output mode (mode field `01`) with push-pull type (`cfg_odrain` bit 0) senses its `out_data` bit.
- R2: An output pin with open-drain type (`cfg_odrain` bit 1) whose `out_data` bit is 0 senses 0.
- R3: An open-drain output pin whose `out_data` bit is 1 senses 1 when disconnected with pull-up (pull field `01`). It senses 0 when disconnected with pull-down (pull field `10`), and 0 when connected to an external low.
- R4: A pin whose mode field is anything other than `01` is an input. When connected, it senses the external level. When disconnected, it senses 1 with pull-up and 0 with pull-down. Pull fields `00` and `11` mean no pull.
- R5: A pin whose level no rule in R1 to R4 determines keeps its previously sensed bit.
- R6: An external drive on an output-mode pin is refused unless the pin is open-drain and the requested level is 0. A refused drive leaves the pin's connection state unchanged and sets that pin's `drive_err` bit.
- R7: On a `cfg_update` pulse, any connected output pin that is push-pull, or that is connected at a high level, becomes disconnected.
- R8: Each `pin_line` bit rises when its resolved bit goes from 0 to 1 and falls when it goes from 1 to 0. An undetermined pin leaves its line unchanged.
- R9: During and right after reset, every pin is disconnected with external level 0, and `sensed`, `pin_line` and `drive_err` are 0.
- R10: A `cfg_update`, drive or release event sampled at clock edge N updates the connection state at edge N. The event is reflected in `sensed` and `pin_line` at edge N+1. With no event, those outputs hold.
- R11: A `drive_err` bit lasts exactly one cycle unless another refused drive follows.
- R12: When a drive and a release reach the same pin in the same cycle, the accepted drive wins and the pin ends up connected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2*NPINS | Per-pin 2-bit direction field, `01` = output |
| cfg_odrain | input | NPINS | Per-pin output type, 1 = open-drain |
| cfg_pull | input | 2*NPINS | Per-pin 2-bit pull field, `01` up, `10` down |
| out_data | input | NPINS | Per-pin output data |
| cfg_update | input | 1 | Pulse: configuration or output data changed |
| ext_drive | input | NPINS | Per-pin external drive request |
| ext_level | input | NPINS | Level for each drive request |
| ext_release | input | NPINS | Per-pin external release request |
| sensed | output | NPINS | Held input-data vector |
| pin_line | output | NPINS | Per-pin output level lines |
| drive_err | output | NPINS | One-cycle flag for each refused drive |

## Verification
A corrupt connection bit stays hidden until the pin's configuration lets it matter. It then shows in `sensed` one edge after the next event. Typical cases are a pull that reads the wrong way after a release, or an open-drain pin that holds a stale 1 instead of taking its pull-down after a mode change. The auto-disconnect and same-cycle drive/release cases are set up so that the faulty and correct outcomes differ in one sensed bit. A wrong refusal decision shows immediately, in `drive_err` at the edge after the request. Its effect on the connection shows one edge later.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;

    typedef enum logic [1:0] {
        MD_IN  = 2'b00,
        MD_OUT = 2'b01,
        MD_ALT = 2'b10,
        MD_ANA = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        PL_NONE = 2'b00,
        PL_UP   = 2'b01,
        PL_DOWN = 2'b10,
        PL_RSV  = 2'b11
    } pin_pull_e;

    typedef struct packed {
        logic det;
        logic val;
    } pin_res_t;

    // Resolve one pin; det=0 means the previous sensed bit is kept.
    function automatic pin_res_t resolve_pin(
        input logic [1:0] mode,
        input logic       odrain,
        input logic [1:0] pull,
        input logic       odata,
        input logic       conn,
        input logic       lvl
    );
        pin_res_t r;
        r.det = 1'b0;
        r.val = 1'b0;
        if (mode == MD_OUT) begin
            if (!odrain) begin
                r.det = 1'b1;
                r.val = odata;
            end else if (!odata) begin
                r.det = 1'b1;
                r.val = 1'b0;
            end else if (!conn && pull == PL_UP) begin
                r.det = 1'b1;
                r.val = 1'b1;
            end else if (!conn && pull == PL_DOWN) begin
                r.det = 1'b1;
                r.val = 1'b0;
            end else if (conn && !lvl) begin
                r.det = 1'b1;
                r.val = 1'b0;
            end
        end else if (conn) begin
            r.det = 1'b1;
            r.val = lvl;
        end else if (pull == PL_UP) begin
            r.det = 1'b1;
            r.val = 1'b1;
        end else if (pull == PL_DOWN) begin
            r.det = 1'b1;
            r.val = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_drive_gate.sv
module gpio_drive_gate #(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0] cfg_mode,
    input  logic [NPINS-1:0]   cfg_odrain,
    input  logic [NPINS-1:0]   ext_drive,
    input  logic [NPINS-1:0]   ext_level,
    output logic [NPINS-1:0]   accept,
    output logic [NPINS-1:0]   reject
);
    import gpio_res_pkg::*;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic is_out;
        logic allowed;
        assign is_out  = (cfg_mode[2*i +: 2] == MD_OUT);
        assign allowed = !is_out || (cfg_odrain[i] && !ext_level[i]);
        assign accept[i] = ext_drive[i] && allowed;
        assign reject[i] = ext_drive[i] && !allowed;
    end

endmodule

// File: rtl/gpio_conn_update.sv
module gpio_conn_update #(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0] cfg_mode,
    input  logic [NPINS-1:0]   cfg_odrain,
    input  logic               cfg_update,
    input  logic [NPINS-1:0]   conn_q,
    input  logic [NPINS-1:0]   lvl_q,
    input  logic [NPINS-1:0]   accept,
    input  logic [NPINS-1:0]   ext_level,
    input  logic [NPINS-1:0]   ext_release,
    output logic [NPINS-1:0]   conn_d,
    output logic [NPINS-1:0]   lvl_d
);
    import gpio_res_pkg::*;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        always_comb begin
            logic c;
            logic l;
            c = conn_q[i];
            l = lvl_q[i];
            if (ext_release[i]) begin
                c = 1'b0;
            end
            // an accepted drive overrides a release in the same cycle
            if (accept[i]) begin
                c = 1'b1;
                l = ext_level[i];
            end
            if (cfg_update && c && cfg_mode[2*i +: 2] == MD_OUT
                && (!cfg_odrain[i] || l)) begin
                c = 1'b0;
            end
            conn_d[i] = c;
            lvl_d[i]  = l;
        end
    end

endmodule

// File: rtl/gpio_level_eval.sv
module gpio_level_eval #(
    parameter int NPINS = 16
) (
    input  logic [2*NPINS-1:0] cfg_mode,
    input  logic [NPINS-1:0]   cfg_odrain,
    input  logic [2*NPINS-1:0] cfg_pull,
    input  logic [NPINS-1:0]   out_data,
    input  logic [NPINS-1:0]   conn_q,
    input  logic [NPINS-1:0]   lvl_q,
    output logic [NPINS-1:0]   det,
    output logic [NPINS-1:0]   val
);
    import gpio_res_pkg::*;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pin_res_t r;
        assign r = resolve_pin(cfg_mode[2*i +: 2], cfg_odrain[i],
                               cfg_pull[2*i +: 2], out_data[i],
                               conn_q[i], lvl_q[i]);
        assign det[i] = r.det;
        assign val[i] = r.val;
    end

endmodule

// File: rtl/gpio_pin_resolver.sv
module gpio_pin_resolver #(
    parameter int NPINS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*NPINS-1:0] cfg_mode,
    input  logic [NPINS-1:0]   cfg_odrain,
    input  logic [2*NPINS-1:0] cfg_pull,
    input  logic [NPINS-1:0]   out_data,
    input  logic               cfg_update,
    input  logic [NPINS-1:0]   ext_drive,
    input  logic [NPINS-1:0]   ext_level,
    input  logic [NPINS-1:0]   ext_release,
    output logic [NPINS-1:0]   sensed,
    output logic [NPINS-1:0]   pin_line,
    output logic [NPINS-1:0]   drive_err
);
    localparam int W = NPINS;

    typedef struct packed {
        logic [W-1:0] conn;
        logic [W-1:0] lvl;
        logic         pend;
        logic [W-1:0] sensed;
        logic [W-1:0] line;
        logic [W-1:0] err;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] accept, reject;
    logic [W-1:0] conn_n, lvl_n;
    logic [W-1:0] res_det, res_val;

    gpio_drive_gate #(.NPINS(W)) u_gate (
        .cfg_mode   (cfg_mode),
        .cfg_odrain (cfg_odrain),
        .ext_drive  (ext_drive),
        .ext_level  (ext_level),
        .accept     (accept),
        .reject     (reject)
    );

    gpio_conn_update #(.NPINS(W)) u_conn (
        .cfg_mode    (cfg_mode),
        .cfg_odrain  (cfg_odrain),
        .cfg_update  (cfg_update),
        .conn_q      (st_q.conn),
        .lvl_q       (st_q.lvl),
        .accept      (accept),
        .ext_level   (ext_level),
        .ext_release (ext_release),
        .conn_d      (conn_n),
        .lvl_d       (lvl_n)
    );

    gpio_level_eval #(.NPINS(W)) u_eval (
        .cfg_mode   (cfg_mode),
        .cfg_odrain (cfg_odrain),
        .cfg_pull   (cfg_pull),
        .out_data   (out_data),
        .conn_q     (st_q.conn),
        .lvl_q      (st_q.lvl),
        .det        (res_det),
        .val        (res_val)
    );

    always_comb begin
        st_d      = st_q;
        st_d.conn = conn_n;
        st_d.lvl  = lvl_n;
        st_d.err  = reject;
        st_d.pend = cfg_update || (|ext_drive) || (|ext_release);
        if (st_q.pend) begin
            st_d.sensed = (st_q.sensed & ~res_det) | (res_val & res_det);
            for (int i = 0; i < W; i++) begin
                if (res_det[i]) begin
                    if (res_val[i] && !st_q.sensed[i]) begin
                        st_d.line[i] = 1'b1;
                    end else if (!res_val[i] && st_q.sensed[i]) begin
                        st_d.line[i] = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.pend   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sensed    = st_q.sensed;
    assign pin_line  = st_q.line;
    assign drive_err = st_q.err;

endmodule

// File: rtl/gpio_pin_resolver_chk.sv
module gpio_pin_resolver_chk #(
    parameter int NPINS = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*NPINS-1:0] cfg_mode,
    input logic [NPINS-1:0]   cfg_odrain,
    input logic [NPINS-1:0]   out_data,
    input logic               cfg_update,
    input logic [NPINS-1:0]   ext_drive,
    input logic [NPINS-1:0]   ext_level,
    input logic [NPINS-1:0]   ext_release,
    input logic [NPINS-1:0]   sensed,
    input logic [NPINS-1:0]   pin_line,
    input logic [NPINS-1:0]   drive_err
);
    logic [NPINS-1:0] out_m;
    for (genvar i = 0; i < NPINS; i++) begin : g_m
        assign out_m[i] = (cfg_mode[2*i +: 2] == 2'b01);
    end

    logic [NPINS-1:0] pp_mask, od0_mask, refuse;
    assign pp_mask  = out_m & ~cfg_odrain;
    assign od0_mask = out_m & cfg_odrain & ~out_data;
    assign refuse   = ext_drive & out_m & ~(cfg_odrain & ~ext_level);

    logic ev_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= 1'b1;
        else        ev_q <= cfg_update || (|ext_drive) || (|ext_release);
    end

    a_r1_pushpull_reads_data: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q |=> (((sensed ^ $past(out_data)) & $past(pp_mask)) == '0));

    a_r2_odrain_low_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ev_q |=> ((sensed & $past(od0_mask)) == '0));

    a_r6_refusal_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drive_err == $past(refuse)));

    a_r11_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ((|drive_err) && !(|ext_drive)) |=> (drive_err == '0));

    a_r10_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_q |=> ($stable(sensed) && $stable(pin_line)));

    a_r8_line_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
        pin_line == sensed);

endmodule

bind gpio_pin_resolver gpio_pin_resolver_chk #(.NPINS(NPINS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_mode    (cfg_mode),
    .cfg_odrain  (cfg_odrain),
    .out_data    (out_data),
    .cfg_update  (cfg_update),
    .ext_drive   (ext_drive),
    .ext_level   (ext_level),
    .ext_release (ext_release),
    .sensed      (sensed),
    .pin_line    (pin_line),
    .drive_err   (drive_err)
);

// File: tb/sim_gpio_pin_resolver.sv
module sim_gpio_pin_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*N-1:0] cfg_mode = '0;
    logic [N-1:0]   cfg_odrain = '0;
    logic [2*N-1:0] cfg_pull = '0;
    logic [N-1:0]   out_data = '0;
    logic           cfg_update = 1'b0;
    logic [N-1:0]   ext_drive = '0;
    logic [N-1:0]   ext_level = '0;
    logic [N-1:0]   ext_release = '0;
    logic [N-1:0]   sensed, pin_line, drive_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [N-1:0] err_mid, sensed_mid;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_pin_resolver #(.NPINS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_odrain(cfg_odrain),
        .cfg_pull(cfg_pull), .out_data(out_data), .cfg_update(cfg_update),
        .ext_drive(ext_drive), .ext_level(ext_level), .ext_release(ext_release),
        .sensed(sensed), .pin_line(pin_line), .drive_err(drive_err)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One event cycle; err_mid/sensed_mid are sampled after edge N, final after N+1.
    task automatic step(input logic cfg, input logic [N-1:0] drv,
                        input logic [N-1:0] lvl, input logic [N-1:0] rel);
        @(negedge clk);
        cfg_update = cfg; ext_drive = drv; ext_level = lvl; ext_release = rel;
        @(negedge clk);
        err_mid = drive_err; sensed_mid = sensed;
        cfg_update = 1'b0; ext_drive = '0; ext_level = '0; ext_release = '0;
        @(negedge clk);
    endtask

    task automatic expect_level(input string tag, input logic [N-1:0] exp);
        check(tag, sensed, exp);
        check({tag, " R8 line"}, pin_line, exp);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R9 sensed in reset", sensed, '0);
        check("R9 line in reset", pin_line, '0);
        check("R9 err in reset", drive_err, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 floating after reset", sensed, '0);
    endtask

    task automatic t_input_pulls;
        cfg_pull = 32'hAAAA_5555;
        step(1'b1, '0, '0, '0);
        check("R10 not yet resolved", sensed_mid, 16'h0000);
        expect_level("R4 pulls", 16'h00FF);
        step(1'b0, 16'h0101, 16'h0100, '0);
        check("R6 input drive accepted", err_mid, '0);
        expect_level("R4 connected level", 16'h01FE);
        step(1'b0, '0, '0, 16'h0101);
        expect_level("R4 release to pulls", 16'h00FF);
    endtask

    task automatic t_floating_hold;
        cfg_pull[7:6] = 2'b00;
        step(1'b1, '0, '0, '0);
        expect_level("R5 float keeps 1", 16'h00FF);
        step(1'b0, 16'h0008, 16'h0000, '0);
        expect_level("R4 pin3 driven low", 16'h00F7);
        step(1'b0, '0, '0, 16'h0008);
        expect_level("R5 float keeps 0", 16'h00F7);
    endtask

    task automatic t_pushpull;
        cfg_mode[31:24] = 8'h55;
        out_data[15:12] = 4'b1010;
        step(1'b1, '0, '0, '0);
        expect_level("R1 push-pull data", 16'hA0F7);
        step(1'b0, 16'h1000, 16'h1000, '0);
        check("R6 push-pull drive refused", err_mid, 16'h1000);
        check("R11 err cleared", drive_err, '0);
        expect_level("R6 refused drive no effect", 16'hA0F7);
    endtask

    task automatic t_open_drain;
        cfg_mode[21:20] = 2'b01;
        cfg_odrain[10] = 1'b1;
        out_data[10] = 1'b0;
        step(1'b1, '0, '0, '0);
        expect_level("R2 open-drain zero", 16'hA0F7);
        out_data[10] = 1'b1;
        cfg_pull[21:20] = 2'b01;
        step(1'b1, '0, '0, '0);
        expect_level("R3 open-drain pull-up", 16'hA4F7);
        cfg_pull[21:20] = 2'b10;
        step(1'b1, '0, '0, '0);
        expect_level("R3 open-drain pull-down", 16'hA0F7);
        cfg_pull[21:20] = 2'b01;
        step(1'b1, '0, '0, '0);
        expect_level("R3 pull-up again", 16'hA4F7);
        step(1'b0, 16'h0400, 16'h0000, '0);
        check("R6 open-drain low drive accepted", err_mid, '0);
        expect_level("R3 connected low", 16'hA0F7);
        step(1'b0, 16'h0400, 16'h0400, '0);
        check("R6 open-drain high drive refused", err_mid, 16'h0400);
        expect_level("R6 connection kept", 16'hA0F7);
        step(1'b0, '0, '0, 16'h0400);
        expect_level("R3 released to pull-up", 16'hA4F7);
    endtask

    task automatic t_auto_disconnect;
        step(1'b0, 16'h0020, 16'h0020, '0);
        expect_level("R4 pin5 driven high", 16'hA4F7);
        cfg_mode[11:10] = 2'b01;
        cfg_odrain[5] = 1'b1;
        out_data[5] = 1'b1;
        cfg_pull[11:10] = 2'b10;
        step(1'b1, '0, '0, '0);
        expect_level("R7 open-drain high disconnected", 16'hA4D7);
        step(1'b0, 16'h0040, 16'h0000, '0);
        expect_level("R4 pin6 driven low", 16'hA497);
        cfg_mode[13:12] = 2'b01;
        step(1'b1, '0, '0, '0);
        expect_level("R1 pin6 push-pull", 16'hA497);
        cfg_mode[13:12] = 2'b00;
        step(1'b1, '0, '0, '0);
        expect_level("R7 push-pull disconnected", 16'hA4D7);
    endtask

    task automatic t_drive_and_release;
        step(1'b0, 16'h0002, 16'h0000, 16'h0002);
        expect_level("R12 drive beats release", 16'hA4D5);
    endtask

    initial begin
        t_reset();
        t_input_pulls();
        t_floating_hold();
        t_pushpull();
        t_open_drain();
        t_auto_disconnect();
        t_drive_and_release();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule